// File: doc/BRIEF.md
# In-System Programming Stage Sequencer

This block programs or checks the nonvolatile configuration array of a target device through a serial test port. It generates a divided test clock and moves fixed-width command frames out on the serial data line. Where a stage needs an answer, it collects response bits from the return line. A pulse of stated duration separates the steps that act on the array. A single start request runs a complete flow. The mode input chooses one of two flows: full programming (enter, identity check, bulk erase, program, verify, exit) or a check of existing contents (enter, identity check, verify, exit).

Pattern words come from a simple request interface. The sequencer presents an array address for one cycle and expects the word on the following cycle. When the flow ends, the block pulses done, with pass when every comparison matched. A failing run holds fail high and keeps the address that failed until the next start. Durations are given in microseconds together with the clock rate in MHz, so a bench can shrink every wait by choosing small values.

Top module: `isp_seq`

## Requirements
- R1: With the mode input low, the frames appear in this stage order: enter, identity request plus readout, one erase, one program frame per address, one verify frame plus readout per address, exit.
- R2: With the mode input high at start, no erase or program frame is sent; the flow is enter, identity request plus readout, verify per address, exit.
- R3: After the enter frame ends, at least ENTER_US times CLK_MHZ clocks pass before the next frame begins.
- R4: The first DW bits returned by the readout that follows the identity request are compared with ID_VALUE. On a mismatch, no erase, program or verify frame follows: the exit frame comes next, fail is raised and the failing address reads 0.
- R5: Bulk erase is exactly one frame with the erase opcode, followed by a wait of at least ERASE_US times CLK_MHZ clocks.
- R6: The program stage sends one frame for each address from 0 to DEPTH-1 in ascending order, carrying that address's pattern word, and waits at least PROG_US times CLK_MHZ clocks after each frame.
- R7: The verify stage sends, for each ascending address, a verify frame carrying the address, waits at least READ_US times CLK_MHZ clocks, then sends a readout frame and compares its first DW returned bits with the pattern word. On the first mismatch the flow goes to exit, fail is raised and fail_addr holds that address.
- R8: After the exit frame, at least EXIT_US times CLK_MHZ clocks pass before done rises. Done is high for exactly one cycle, and pass is high with it only when no mismatch occurred.
- R9: The test clock has a period of 2*TCK_HALF system clocks and idles low. The data line changes only while the test clock is low, and response bits are taken at its rising edge. Each frame is FRAME_W bits long and sent LSB first, with the opcode in bits [OP_W-1:0], the address in the next AW bits and the data word in the top DW bits. Non-data fields are zero.
- R10: pat_req is high for single cycles with pat_addr valid. pat_data is taken on the following cycle, and there is one request per program or verify address visited.
- R11: fail stays high after a failing run until the next start, and the next start clears it.
- R12: After reset, busy, done, pass, fail and the test clock are low, and stage reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a flow (taken when idle) |
| verify_only | input | 1 | Mode captured at start: 1 = check only, 0 = full programming |
| pat_req | output | 1 | Pattern word request strobe |
| pat_addr | output | AW | Address of the requested pattern word |
| pat_data | input | DW | Pattern word, valid the cycle after pat_req |
| tck | output | 1 | Divided test clock |
| tdi | output | 1 | Serial data toward the target |
| tdo | input | 1 | Serial data from the target |
| busy | output | 1 | A flow is running |
| stage | output | 3 | Current stage: 0 idle, 1 enter, 2 identity, 3 erase, 4 program, 5 verify, 6 exit |
| done | output | 1 | One-cycle end-of-flow strobe |
| pass | output | 1 | High with done when all comparisons matched |
| fail | output | 1 | Held high after a mismatch until next start |
| fail_addr | output | AW | Address of the mismatch (0 for identity) |

## Verification
The hardest case to reach from the ports is a verify mismatch in the middle of the array after a good identity check, because the array was written correctly by the block itself just before. The bench's target model keeps its own copy of the array. After a clean full-programming run it flips one bit at a middle address and then starts a check-only run. The scoreboard then expects exactly the verify frames up to that address followed at once by exit, and a later identity-mismatch run confirms that the corrupted contents were left untouched.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ENTER  = 3'd1,
    ST_CHKID  = 3'd2,
    ST_ERASE  = 3'd3,
    ST_PROG   = 3'd4,
    ST_VERIFY = 3'd5,
    ST_EXIT   = 3'd6
  } stage_e;

  typedef enum logic [3:0] {
    SP_IDLE,
    SP_FETCH,
    SP_FETCH_W,
    SP_CMD,
    SP_CMD_W,
    SP_PULSE_W,
    SP_RD,
    SP_RD_W,
    SP_NEXT
  } step_e;

  // Stage that follows s when no mismatch has occurred.
  function automatic stage_e next_stage(stage_e s, logic vonly);
    case (s)
      ST_ENTER:  return ST_CHKID;
      ST_CHKID:  return vonly ? ST_VERIFY : ST_ERASE;
      ST_ERASE:  return ST_PROG;
      ST_PROG:   return ST_VERIFY;
      ST_VERIFY: return ST_EXIT;
      default:   return ST_IDLE;
    endcase
  endfunction

  // Stages that walk the array and fetch a pattern word per address.
  function automatic logic stage_loops(stage_e s);
    return (s == ST_PROG) || (s == ST_VERIFY);
  endfunction

  // Stages that follow their command with a readout frame.
  function automatic logic stage_reads(stage_e s);
    return (s == ST_CHKID) || (s == ST_VERIFY);
  endfunction

  // Duration in microseconds to system clock cycles.
  function automatic logic [31:0] us_to_cycles(int unsigned mhz, int unsigned us);
    return 32'(mhz * us);
  endfunction

endpackage

// File: rtl/isp_pulse_timer.sv
module isp_pulse_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cycles,
  output logic          active,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start && !active) begin
        cnt_q  <= cycles;
        active <= 1'b1;
      end else if (active) begin
        if (cnt_q <= CW'(1)) begin
          active <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R3/R5: an expiry only ends a running wait
  a_r3_expire_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(active));
  // R5: a wait is never restarted while it is running
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/isp_tck_shifter.sv
module isp_tck_shifter #(
  parameter int FW    = 16,
  parameter int CAP_W = 8,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FW-1:0]    word,
  input  logic             tdo,
  output logic             tck,
  output logic             tdi,
  output logic             busy,
  output logic             done,
  output logic [CAP_W-1:0] cap
);

  localparam int IW  = (FW > 1) ? $clog2(FW) : 1;
  localparam int CIW = (CAP_W > 1) ? $clog2(CAP_W) : 1;
  localparam int HW  = $clog2(HALF) + 1;

  logic [FW-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nx;
  logic [HW-1:0] hc_q;
  logic          half_end;

  assign idx_nx   = idx_q + 1'b1;
  assign half_end = (hc_q == HW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      hc_q  <= '0;
      tck   <= 1'b0;
      tdi   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      cap   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh_q  <= word;
        tdi   <= word[0];
        busy  <= 1'b1;
        hc_q  <= '0;
        idx_q <= '0;
      end else if (busy) begin
        if (half_end) begin
          hc_q <= '0;
          if (!tck) begin
            tck <= 1'b1;
            if (idx_q < IW'(CAP_W))
              cap[idx_q[CIW-1:0]] <= tdo;
          end else begin
            tck <= 1'b0;
            if (idx_q == IW'(FW - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              idx_q <= idx_nx;
              tdi   <= sh_q[idx_nx];
            end
          end
        end else begin
          hc_q <= hc_q + 1'b1;
        end
      end
    end
  end

  // R9: data line holds while the test clock is high
  a_r9_tdi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    tck |-> $stable(tdi));
  // R9: test clock idles low between frames
  a_r9_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  // R9: frame completion is a single-cycle event
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import isp_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned ENTER_US = 1000,
  parameter int unsigned ERASE_US = 100000,
  parameter int unsigned PROG_US  = 100,
  parameter int unsigned READ_US  = 2,
  parameter int unsigned EXIT_US  = 1000,
  parameter int          TCK_HALF = 5,
  parameter int          DEPTH    = 16,
  parameter int          DW       = 8,
  parameter int          OP_W     = 4,
  parameter int          AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter logic [DW-1:0]   ID_VALUE   = 8'hA5,
  parameter logic [OP_W-1:0] OP_ENTER   = 4'h1,
  parameter logic [OP_W-1:0] OP_IDCODE  = 4'h2,
  parameter logic [OP_W-1:0] OP_ERASE   = 4'h3,
  parameter logic [OP_W-1:0] OP_PROG    = 4'h4,
  parameter logic [OP_W-1:0] OP_VERIFY  = 4'h5,
  parameter logic [OP_W-1:0] OP_READOUT = 4'h6,
  parameter logic [OP_W-1:0] OP_EXIT    = 4'h7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          verify_only,
  output logic          pat_req,
  output logic [AW-1:0] pat_addr,
  input  logic [DW-1:0] pat_data,
  output logic          tck,
  output logic          tdi,
  input  logic          tdo,
  output logic          busy,
  output logic [2:0]    stage,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);

  localparam int        FRAME_W   = OP_W + AW + DW;
  localparam int        TW        = 32;
  localparam logic [TW-1:0] ENTER_CYC = us_to_cycles(CLK_MHZ, ENTER_US);
  localparam logic [TW-1:0] ERASE_CYC = us_to_cycles(CLK_MHZ, ERASE_US);
  localparam logic [TW-1:0] PROG_CYC  = us_to_cycles(CLK_MHZ, PROG_US);
  localparam logic [TW-1:0] READ_CYC  = us_to_cycles(CLK_MHZ, READ_US);
  localparam logic [TW-1:0] EXIT_CYC  = us_to_cycles(CLK_MHZ, EXIT_US);

  stage_e        stage_q;
  step_e         step_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          vonly_q;
  logic          fail_q;
  logic [AW-1:0] fail_addr_q;
  logic          done_q;
  logic          pass_q;

  // Named internal events
  logic               sh_start;
  logic [FRAME_W-1:0] sh_word;
  logic               sh_done;
  logic               sh_busy;
  logic [DW-1:0]      sh_cap;
  logic               tm_start;
  logic               tm_active;
  logic               tm_expire;
  logic [TW-1:0]      pulse_cyc;
  logic [OP_W-1:0]    cmd_op;
  logic [DW-1:0]      expect_word;
  logic               cmp_mismatch;
  logic               last_addr;

  always_comb begin
    case (stage_q)
      ST_ENTER:  begin cmd_op = OP_ENTER;  pulse_cyc = ENTER_CYC; end
      ST_CHKID:  begin cmd_op = OP_IDCODE; pulse_cyc = '0;        end
      ST_ERASE:  begin cmd_op = OP_ERASE;  pulse_cyc = ERASE_CYC; end
      ST_PROG:   begin cmd_op = OP_PROG;   pulse_cyc = PROG_CYC;  end
      ST_VERIFY: begin cmd_op = OP_VERIFY; pulse_cyc = READ_CYC;  end
      ST_EXIT:   begin cmd_op = OP_EXIT;   pulse_cyc = EXIT_CYC;  end
      default:   begin cmd_op = '0;        pulse_cyc = '0;        end
    endcase
  end

  always_comb begin
    if (step_q == SP_RD)
      sh_word = {{DW{1'b0}}, {AW{1'b0}}, OP_READOUT};
    else if (stage_q == ST_PROG)
      sh_word = {data_q, addr_q, cmd_op};
    else if (stage_q == ST_VERIFY)
      sh_word = {{DW{1'b0}}, addr_q, cmd_op};
    else
      sh_word = {{DW{1'b0}}, {AW{1'b0}}, cmd_op};
  end

  assign sh_start     = (step_q == SP_CMD) || (step_q == SP_RD);
  assign tm_start     = (step_q == SP_CMD_W) && sh_done && (pulse_cyc != '0);
  assign pat_req      = (step_q == SP_FETCH);
  assign pat_addr     = addr_q;
  assign expect_word  = (stage_q == ST_CHKID) ? ID_VALUE : data_q;
  assign cmp_mismatch = (step_q == SP_RD_W) && sh_done && (sh_cap != expect_word);
  assign last_addr    = (addr_q == AW'(DEPTH - 1));

  isp_tck_shifter #(
    .FW   (FRAME_W),
    .CAP_W(DW),
    .HALF (TCK_HALF)
  ) shift_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(sh_start),
    .word (sh_word),
    .tdo  (tdo),
    .tck  (tck),
    .tdi  (tdi),
    .busy (sh_busy),
    .done (sh_done),
    .cap  (sh_cap)
  );

  isp_pulse_timer #(
    .CW(TW)
  ) pulse_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tm_start),
    .cycles(pulse_cyc),
    .active(tm_active),
    .expire(tm_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= ST_IDLE;
      step_q      <= SP_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      vonly_q     <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      case (step_q)
        SP_IDLE: begin
          if (start) begin
            stage_q     <= ST_ENTER;
            step_q      <= SP_CMD;
            addr_q      <= '0;
            vonly_q     <= verify_only;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
          end
        end
        SP_FETCH:   step_q <= SP_FETCH_W;
        SP_FETCH_W: begin
          data_q <= pat_data;
          step_q <= SP_CMD;
        end
        SP_CMD:     step_q <= SP_CMD_W;
        SP_CMD_W: begin
          if (sh_done) begin
            if (pulse_cyc != '0)          step_q <= SP_PULSE_W;
            else if (stage_reads(stage_q)) step_q <= SP_RD;
            else                          step_q <= SP_NEXT;
          end
        end
        SP_PULSE_W: begin
          if (tm_expire)
            step_q <= stage_reads(stage_q) ? SP_RD : SP_NEXT;
        end
        SP_RD:      step_q <= SP_RD_W;
        SP_RD_W: begin
          if (sh_done) begin
            if (cmp_mismatch) begin
              fail_q      <= 1'b1;
              fail_addr_q <= (stage_q == ST_CHKID) ? '0 : addr_q;
              stage_q     <= ST_EXIT;
              step_q      <= SP_CMD;
            end else begin
              step_q <= SP_NEXT;
            end
          end
        end
        SP_NEXT: begin
          if (stage_loops(stage_q) && !last_addr) begin
            addr_q <= addr_q + 1'b1;
            step_q <= SP_FETCH;
          end else if (stage_q == ST_EXIT) begin
            done_q  <= 1'b1;
            pass_q  <= !fail_q;
            stage_q <= ST_IDLE;
            step_q  <= SP_IDLE;
          end else begin
            stage_q <= next_stage(stage_q, vonly_q);
            addr_q  <= '0;
            step_q  <= stage_loops(next_stage(stage_q, vonly_q)) ? SP_FETCH : SP_CMD;
          end
        end
        default: step_q <= SP_IDLE;
      endcase
    end
  end

  assign busy      = (stage_q != ST_IDLE);
  assign stage     = stage_q;
  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;

  // R1: a running flow advances only to its successor stage or to exit
  a_r1_stage_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage_q) != stage_q && $past(stage_q) != ST_IDLE
     && stage_q != ST_EXIT && stage_q != ST_IDLE)
    |-> stage_q == next_stage($past(stage_q), vonly_q));
  // R2: check-only runs never reach erase or program
  a_r2_vonly_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (vonly_q && busy) |-> (stage_q != ST_ERASE && stage_q != ST_PROG));
  // R4/R7: a new failure always sends the flow to exit
  a_r4_fail_to_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> stage_q == ST_EXIT);
  // R8: pass only accompanies done
  a_r8_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  // R8/R11: each completion reports exactly one of pass or fail
  a_r11_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  // R10: pattern requests are single-cycle strobes
  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    pat_req |=> !pat_req);
  // R3/R5: no frame is shifted while a pulse wait runs
  a_r5_quiet_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tm_active |-> !sh_busy);

endmodule

// File: tb/isp_seq_tb_top.sv
module isp_seq_tb_top;

  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int OPW   = 4;
  localparam int FW    = OPW + AW + DW;
  localparam int HALF  = 2;
  localparam int ENTER_C = 40, ERASE_C = 150, PROG_C = 6, READ_C = 3, EXIT_C = 30;
  localparam int SLACK = 4 * HALF + 8;
  localparam logic [3:0] O_EN = 4'h1, O_ID = 4'h2, O_ER = 4'h3, O_PG = 4'h4,
                         O_VF = 4'h5, O_RD = 4'h6, O_EX = 4'h7;
  localparam logic [7:0] GOOD_ID = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic verify_only = 1'b0;
  logic pat_req;
  logic [AW-1:0] pat_addr;
  logic [DW-1:0] pat_data = '0;
  logic tck, tdi;
  logic tdo = 1'b0;
  logic busy, done, pass, fail;
  logic [2:0] stage;
  logic [AW-1:0] fail_addr;

  always #10 clk = ~clk;

  isp_seq #(
    .CLK_MHZ(1), .ENTER_US(ENTER_C), .ERASE_US(ERASE_C), .PROG_US(PROG_C),
    .READ_US(READ_C), .EXIT_US(EXIT_C), .TCK_HALF(HALF), .DEPTH(DEPTH),
    .DW(DW), .OP_W(OPW), .ID_VALUE(GOOD_ID),
    .OP_ENTER(O_EN), .OP_IDCODE(O_ID), .OP_ERASE(O_ER), .OP_PROG(O_PG),
    .OP_VERIFY(O_VF), .OP_READOUT(O_RD), .OP_EXIT(O_EX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .verify_only(verify_only),
    .pat_req(pat_req), .pat_addr(pat_addr), .pat_data(pat_data),
    .tck(tck), .tdi(tdi), .tdo(tdo), .busy(busy), .stage(stage),
    .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] pat_of(input int a);
    return 8'(a * 37 + 5);
  endfunction

  function automatic logic [FW-1:0] fr(input logic [3:0] op, input int a, input logic [7:0] d);
    return {d, 4'(a), op};
  endfunction

  // Pattern source: word valid the cycle after the request.
  always @(posedge clk) if (pat_req) pat_data <= pat_of(int'(pat_addr));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard and target model state
  logic [FW-1:0] sbq[$];
  logic [7:0] tgt_mem [DEPTH];
  logic [7:0] tgt_id = GOOD_ID;
  logic [FW-1:0] resp = '0;
  logic [FW-1:0] rx = '0;
  int   bitcnt = 0, end_cyc = 0, rise_cyc = 0;
  logic [3:0] last_op = '0;
  logic prev_tck = 0, tdi_hold = 0, prev_done = 0, prev_req = 0;
  bit   period_checked = 0, done_seen = 0;
  int   tdi_bad = 0, req_cnt = 0, req_bad = 0;
  logic done_pass = 0, done_fail = 0;
  logic [AW-1:0] done_addr = '0;

  // Monitor: samples on the falling system clock edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck && !prev_tck) begin
        if (bitcnt == 0) begin
          int gap;
          gap = cyc - end_cyc;
          case (last_op)
            O_EN: check(gap >= ENTER_C && gap <= ENTER_C + SLACK, "R3 enter hold", gap, ENTER_C);
            O_ER: check(gap >= ERASE_C && gap <= ERASE_C + SLACK, "R5 erase pulse", gap, ERASE_C);
            O_PG: check(gap >= PROG_C && gap <= PROG_C + SLACK, "R6 program pulse", gap, PROG_C);
            O_VF: check(gap >= READ_C && gap <= READ_C + SLACK, "R7 read pulse", gap, READ_C);
            default: ;
          endcase
        end else if (bitcnt == 1 && !period_checked) begin
          check(cyc - rise_cyc == 2 * HALF, "R9 tck period", cyc - rise_cyc, 2 * HALF);
          period_checked = 1;
        end
        rise_cyc = cyc;
        rx[bitcnt] = tdi;
        tdi_hold = tdi;
        bitcnt++;
      end else if (tck && tdi !== tdi_hold) begin
        tdi_bad++;
      end
      if (!tck && prev_tck) begin
        if (bitcnt == FW) begin
          logic [FW-1:0] e;
          bitcnt = 0;
          end_cyc = cyc;
          if (sbq.size() == 0) begin
            check(0, "R1 R2 unexpected frame", int'(rx), 0);
          end else begin
            e = sbq.pop_front();
            check(rx == e, "R1 R2 R9 frame content", int'(rx), int'(e));
          end
          case (rx[3:0])
            O_ER: for (int i = 0; i < DEPTH; i++) tgt_mem[i] = 8'hFF;
            O_PG: tgt_mem[rx[7:4]] = rx[15:8];
            O_VF: resp = {8'h00, tgt_mem[rx[7:4]]};
            O_ID: resp = {8'h00, tgt_id};
            default: resp = '0;
          endcase
          last_op = rx[3:0];
        end
        tdo = (bitcnt < FW) ? resp[bitcnt] : 1'b0;
      end
      prev_tck = tck;
      if (pat_req) begin
        req_cnt++;
        if (prev_req) req_bad++;
      end
      prev_req = pat_req;
      if (done) begin
        done_seen = 1;
        done_pass = pass;
        done_fail = fail;
        done_addr = fail_addr;
        check(cyc - end_cyc >= EXIT_C && cyc - end_cyc <= EXIT_C + SLACK,
              "R8 exit hold", cyc - end_cyc, EXIT_C);
        if (prev_done) check(0, "R8 done width", 2, 1);
      end
      prev_done = done;
    end
  end

  // Driver: pushes the expected frame sequence of one run.
  task automatic push_expected(input bit vo, input int bad_at, input bit id_bad);
    int last;
    sbq.push_back(fr(O_EN, 0, 8'h00));
    sbq.push_back(fr(O_ID, 0, 8'h00));
    sbq.push_back(fr(O_RD, 0, 8'h00));
    if (!id_bad) begin
      if (!vo) begin
        sbq.push_back(fr(O_ER, 0, 8'h00));
        for (int a = 0; a < DEPTH; a++) sbq.push_back(fr(O_PG, a, pat_of(a)));
      end
      last = (bad_at >= 0) ? bad_at : DEPTH - 1;
      for (int a = 0; a <= last; a++) begin
        sbq.push_back(fr(O_VF, a, 8'h00));
        sbq.push_back(fr(O_RD, 0, 8'h00));
      end
    end
    sbq.push_back(fr(O_EX, 0, 8'h00));
  endtask

  task automatic run(input bit vo, input int bad_at, input bit id_bad, input int exp_req);
    push_expected(vo, bad_at, id_bad);
    last_op = '0; period_checked = 0; tdi_bad = 0; req_cnt = 0; req_bad = 0; done_seen = 0;
    @(negedge clk);
    start = 1'b1; verify_only = vo;
    @(negedge clk);
    start = 1'b0;
    check(fail == 1'b0, "R11 start clears fail", fail, 0);
    while (!done_seen) @(negedge clk);
    check(sbq.size() == 0, "R1 R2 all frames seen", sbq.size(), 0);
    check(tdi_bad == 0, "R9 tdi stable while tck high", tdi_bad, 0);
    check(req_cnt == exp_req && req_bad == 0, "R10 request count", req_cnt, exp_req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tgt_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!busy && !done && !pass && !fail && !tck && stage == 3'd0,
          "R12 reset outputs", {busy, done, pass, fail, tck, stage}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Full programming, good identity
    run(0, -1, 0, 2 * DEPTH);
    check(done_pass && !done_fail, "R8 full run passes", {done_pass, done_fail}, 2'b10);
    for (int a = 0; a < DEPTH; a++)
      check(tgt_mem[a] == pat_of(a), "R6 array written", tgt_mem[a], pat_of(a));

    // Check-only, matching contents
    run(1, -1, 0, DEPTH);
    check(done_pass && !done_fail, "R2 check-only passes", {done_pass, done_fail}, 2'b10);

    // Check-only with a corrupted middle word
    tgt_mem[5] = tgt_mem[5] ^ 8'h10;
    run(1, 5, 0, 6);
    check(!done_pass && done_fail, "R7 mismatch reported", {done_pass, done_fail}, 2'b01);
    check(done_addr == 4'd5, "R7 failing address", done_addr, 5);
    repeat (20) @(negedge clk);
    check(fail && fail_addr == 4'd5, "R11 fail held", {fail, fail_addr}, {1'b1, 4'd5});

    // Full programming with the wrong identity
    tgt_id = 8'h3C;
    run(0, -1, 1, 0);
    check(!done_pass && done_fail, "R4 identity mismatch fails", {done_pass, done_fail}, 2'b01);
    check(done_addr == 4'd0, "R4 identity fail address", done_addr, 0);
    check(tgt_mem[5] == (pat_of(5) ^ 8'h10), "R4 array untouched", tgt_mem[5], pat_of(5) ^ 8'h10);

    // Identity restored: erase and reprogram repair the array
    tgt_id = GOOD_ID;
    run(0, -1, 0, 2 * DEPTH);
    check(done_pass && !fail, "R5 R8 rerun passes", {done_pass, fail}, 2'b10);
    check(tgt_mem[5] == pat_of(5), "R6 word repaired", tgt_mem[5], pat_of(5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule